// File: doc/BRIEF.md
# Sleep Mode Controller

This block sits beside a small processor core and decides when the core and its clock domains may stop and how they start again. When software executes the sleep instruction (signalled by a one-cycle strobe) while the sleep-enable bit is set, the controller captures the 3-bit mode code and the brown-out-off request, then gates the clock domains that the chosen mode stops. Unless that bit is set, the strobe changes nothing.

While asleep the controller watches the interrupt request lines, each masked by its own enable, and a reset request. Either one wakes the core. Modes that stop the oscillator first wait in a start-up state until the oscillator reports itself ready. Modes that leave it running skip that wait. Every wake-up then holds the core for a fixed halt of `HALT_CYCLES` (four) clocks before a one-cycle resume pulse releases it. The wake-cause output tells the core where to continue. A reset request selects the reset vector. An interrupt selects the handler, after which execution continues at the instruction that follows the sleep instruction. The controller never drives a clear to the register file or data memory.

The controller has four states. ACTIVE is normal running. SLEEP has the clocks gated. STARTUP waits for the oscillator. HALT is the fixed hold after wake-up. It makes these transitions:
- enter: ACTIVE to SLEEP.
- wake_fast: SLEEP to HALT, in modes that keep the oscillator running.
- wake_slow: SLEEP to STARTUP, in modes that stop the oscillator.
- osc_up: STARTUP to HALT.
- release: HALT to ACTIVE.

Top module: `sleep_ctl`

## Requirements
- R1: A strobe on `sleep_strobe` moves ACTIVE to SLEEP only if `sleep_en` is 1 in the same cycle. If `sleep_en` is 0, the strobe has no effect and the block stays ACTIVE with all clocks running.
- R2: The mode code selects `clk_en` during SLEEP and STARTUP. The bits of `clk_en` are: bit0 CPU, bit1 I/O, bit2 converter, bit3 async timer, with 1 meaning running. The codes map as follows:
  - 0 Idle: 4'b1110.
  - 1 converter-quiet: 4'b1100.
  - 2 Power-down: 4'b0000.
  - 3 Power-save: 4'b1000.
  - 6 Standby: 4'b0000.
  - 7 Extended standby: 4'b1000.
  - Codes 4 and 5 behave as Idle.
  - In ACTIVE and HALT, `clk_en` is 4'b1111.
- R3: In SLEEP, a request on a line whose enable bit is 1 causes a wake-up at the next clock edge. A request on a line whose enable bit is 0 leaves the block in SLEEP.
- R4: Only codes 2 and 3 stop the oscillator. In those modes `osc_en` is 0 during SLEEP. A wake-up then goes to STARTUP with `osc_en` at 1, and the block stays there until `osc_ready` is 1. All other modes go straight from SLEEP to HALT.
- R5: HALT lasts exactly `HALT_CYCLES` (4) cycles. The block then goes to ACTIVE, and `resume_go` is 1 for exactly the first ACTIVE cycle.
- R6: `core_halt` is 1 in every state except ACTIVE. `status` encodes the states as 0 ACTIVE, 1 SLEEP, 2 STARTUP and 3 HALT.
- R7: `wake_cause` is 1 (reset vector) after `rst_n` and after a wake-up from `ext_rst_req`. It is 0 (resume after the sleep instruction) after an interrupt wake-up. When both arrive in the same cycle, the reset request wins. Outside SLEEP, `ext_rst_req` has no effect.
- R8: `bod_disable` is 1 only in SLEEP, and only when `bod_off_req` was 1 at entry and the mode code is 2, 3, 6 or 7.
- R9: The mode code and the brown-out request are captured at entry. Changing `mode_sel` or `bod_off_req` during sleep has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_en | input | 1 | Sleep-enable bit |
| mode_sel | input | 3 | Sleep mode code |
| sleep_strobe | input | 1 | One-cycle sleep instruction strobe |
| bod_off_req | input | 1 | Request to turn off brown-out detection while asleep |
| irq_req | input | N_IRQ | Interrupt request lines |
| irq_en | input | N_IRQ | Per-line interrupt enables |
| ext_rst_req | input | 1 | Reset request, which wakes the core to the reset vector |
| osc_ready | input | 1 | Oscillator start-up complete |
| clk_en | output | 4 | Per-domain clock enables |
| osc_en | output | 1 | Oscillator run enable |
| core_halt | output | 1 | Core held |
| bod_disable | output | 1 | Brown-out detector off |
| wake_cause | output | 1 | 1 = reset vector, 0 = resume after sleep instruction |
| resume_go | output | 1 | One-cycle pulse when the core is released |
| status | output | 2 | Current state |

## Verification
The checker enforces the following on every cycle:
- a strobe with `sleep_en` at 0 never leaves ACTIVE;
- SLEEP never exits without an enabled request or a reset request;
- STARTUP never ends before `osc_ready`;
- HALT lasts exactly four cycles;
- `core_halt` follows the state;
- `bod_disable` appears only in a permitted mode;
- a reset-request wake always yields the reset-vector cause.

Only the bench scenarios can show the following:
- the exact clock-enable mask for each mode code, including the reserved codes;
- that a mode change made while asleep leaves the mask untouched;
- the timing of the single `resume_go` pulse;
- that the reset request wins over an interrupt that arrives in the same cycle.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
    localparam int NDOM = 4;

    typedef enum logic [1:0] {
        ST_ACTIVE  = 2'd0,
        ST_SLEEP   = 2'd1,
        ST_STARTUP = 2'd2,
        ST_HALT    = 2'd3
    } slp_state_t;

    typedef struct packed {
        logic [NDOM-1:0] run_mask;  // bit0 cpu, bit1 io, bit2 converter, bit3 async timer
        logic            osc_keep;  // oscillator stays on while asleep
        logic            bod_ok;    // brown-out detector may be turned off
    } mode_attr_t;
endpackage

// File: rtl/sleep_mode_decode.sv
module sleep_mode_decode
    import sleep_pkg::*;
(
    input  logic [2:0] code,
    output mode_attr_t attr
);
    always_comb begin
        unique case (code)
            3'd1:    attr = '{run_mask: 4'b1100, osc_keep: 1'b1, bod_ok: 1'b0};
            3'd2:    attr = '{run_mask: 4'b0000, osc_keep: 1'b0, bod_ok: 1'b1};
            3'd3:    attr = '{run_mask: 4'b1000, osc_keep: 1'b0, bod_ok: 1'b1};
            3'd6:    attr = '{run_mask: 4'b0000, osc_keep: 1'b1, bod_ok: 1'b1};
            3'd7:    attr = '{run_mask: 4'b1000, osc_keep: 1'b1, bod_ok: 1'b1};
            default: attr = '{run_mask: 4'b1110, osc_keep: 1'b1, bod_ok: 1'b0}; // 0, 4, 5
        endcase
    end
endmodule

// File: rtl/sleep_wake_detect.sv
module sleep_wake_detect #(
    parameter int N_IRQ = 8
) (
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             rst_req,
    output logic             wake,
    output logic             cause_rst
);
    logic irq_hit;

    always_comb begin
        irq_hit   = |(irq_req & irq_en);
        wake      = rst_req | irq_hit;
        cause_rst = rst_req;
    end
endmodule

// File: rtl/sleep_halt_timer.sv
module sleep_halt_timer #(
    parameter int HALT_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int CW = (HALT_CYCLES > 1) ? $clog2(HALT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST_VAL = CW'(HALT_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    always_comb last = run && (cnt_q == LAST_VAL);
endmodule

// File: rtl/sleep_ctl.sv
module sleep_ctl
    import sleep_pkg::*;
#(
    parameter int N_IRQ       = 8,
    parameter int HALT_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_en,
    input  logic [2:0]       mode_sel,
    input  logic             sleep_strobe,
    input  logic             bod_off_req,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             ext_rst_req,
    input  logic             osc_ready,
    output logic [NDOM-1:0]  clk_en,
    output logic             osc_en,
    output logic             core_halt,
    output logic             bod_disable,
    output logic             wake_cause,
    output logic             resume_go,
    output logic [1:0]       status
);
    slp_state_t state_q, state_d;
    logic [2:0] mode_q;
    logic       bod_q;
    logic       cause_q;
    logic       go_q;
    mode_attr_t attr;
    logic       wake, wake_rst, halt_last;

    sleep_mode_decode u_dec (.code(mode_q), .attr(attr));

    sleep_wake_detect #(.N_IRQ(N_IRQ)) u_wake (
        .irq_req(irq_req), .irq_en(irq_en), .rst_req(ext_rst_req),
        .wake(wake), .cause_rst(wake_rst)
    );

    sleep_halt_timer #(.HALT_CYCLES(HALT_CYCLES)) u_halt (
        .clk(clk), .rst_n(rst_n), .run(state_q == ST_HALT), .last(halt_last)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE:  if (sleep_strobe && sleep_en) state_d = ST_SLEEP;
            ST_SLEEP:   if (wake) state_d = attr.osc_keep ? ST_HALT : ST_STARTUP;
            ST_STARTUP: if (osc_ready) state_d = ST_HALT;
            ST_HALT:    if (halt_last) state_d = ST_ACTIVE;
        endcase
    end

    // state register and captured context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ACTIVE;
            mode_q  <= 3'd0;
            bod_q   <= 1'b0;
            cause_q <= 1'b1;
            go_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            go_q    <= (state_q == ST_HALT) && halt_last;
            if (state_q == ST_ACTIVE && sleep_strobe && sleep_en) begin
                mode_q <= mode_sel;
                bod_q  <= bod_off_req;
            end
            if (state_q == ST_SLEEP && wake) cause_q <= wake_rst;
        end
    end

    // outputs, from registered state only
    always_comb begin
        clk_en      = {NDOM{1'b1}};
        osc_en      = 1'b1;
        bod_disable = 1'b0;
        unique case (state_q)
            ST_ACTIVE:  ;
            ST_SLEEP: begin
                clk_en      = attr.run_mask;
                osc_en      = attr.osc_keep;
                bod_disable = bod_q && attr.bod_ok;
            end
            ST_STARTUP: clk_en = attr.run_mask;
            ST_HALT:    ;
        endcase
        core_halt  = (state_q != ST_ACTIVE);
        wake_cause = cause_q;
        resume_go  = go_q;
        status     = state_q;
    end
endmodule

// File: rtl/sleep_ctl_chk.sv
module sleep_ctl_chk #(
    parameter int N_IRQ       = 8,
    parameter int HALT_CYCLES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sleep_en,
    input logic             sleep_strobe,
    input logic [N_IRQ-1:0] irq_req,
    input logic [N_IRQ-1:0] irq_en,
    input logic             ext_rst_req,
    input logic             osc_ready,
    input logic [1:0]       status,
    input logic [2:0]       mode_q,
    input logic             core_halt,
    input logic             bod_disable,
    input logic             wake_cause
);
    localparam int HW = $clog2(HALT_CYCLES + 1);
    logic [HW-1:0] hc;

    always_ff @(posedge clk) begin
        if (!rst_n || status != 2'd3) hc <= '0;
        else                          hc <= hc + 1'b1;
    end

    a_r1_no_sleep_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'd0 && sleep_strobe && !sleep_en) |=> status == 2'd0);

    a_r3_no_wake_without_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'd1 && !ext_rst_req && ((irq_req & irq_en) == '0)) |=> status == 2'd1);

    a_r4_startup_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'd2 && !osc_ready) |=> status == 2'd2);

    a_r5_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'd3 && hc < HW'(HALT_CYCLES - 1)) |=> status == 2'd3);

    a_r5_halt_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'd3 && hc == HW'(HALT_CYCLES - 1)) |=> status == 2'd0);

    a_r6_core_held: assert property (@(posedge clk) disable iff (!rst_n)
        (status != 2'd0) |-> core_halt);

    a_r7_reset_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'd1 && ext_rst_req) |=> wake_cause);

    a_r8_bod_deep_only: assert property (@(posedge clk) disable iff (!rst_n)
        bod_disable |-> (status == 2'd1 && mode_q inside {3'd2, 3'd3, 3'd6, 3'd7}));
endmodule

bind sleep_ctl sleep_ctl_chk #(.N_IRQ(N_IRQ), .HALT_CYCLES(HALT_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en), .sleep_strobe(sleep_strobe),
    .irq_req(irq_req), .irq_en(irq_en), .ext_rst_req(ext_rst_req), .osc_ready(osc_ready),
    .status(status), .mode_q(mode_q), .core_halt(core_halt),
    .bod_disable(bod_disable), .wake_cause(wake_cause)
);

// File: tb/sim_sleep_ctl.sv
`timescale 1ns/1ps
module sim_sleep_ctl;
    localparam int N_IRQ = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sleep_en = 1'b0;
    logic [2:0]       mode_sel = 3'd0;
    logic             sleep_strobe = 1'b0;
    logic             bod_off_req = 1'b0;
    logic [N_IRQ-1:0] irq_req = '0;
    logic [N_IRQ-1:0] irq_en = '0;
    logic             ext_rst_req = 1'b0;
    logic             osc_ready = 1'b0;
    logic [3:0]       clk_en;
    logic             osc_en, core_halt, bod_disable, wake_cause, resume_go;
    logic [1:0]       status;

    sleep_ctl #(.N_IRQ(N_IRQ), .HALT_CYCLES(4)) u0 (
        .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en), .mode_sel(mode_sel),
        .sleep_strobe(sleep_strobe), .bod_off_req(bod_off_req), .irq_req(irq_req),
        .irq_en(irq_en), .ext_rst_req(ext_rst_req), .osc_ready(osc_ready),
        .clk_en(clk_en), .osc_en(osc_en), .core_halt(core_halt),
        .bod_disable(bod_disable), .wake_cause(wake_cause), .resume_go(resume_go),
        .status(status)
    );

    always #10 clk = ~clk;

    typedef struct {
        int         tag;
        logic [1:0] st;
        logic [3:0] ce;
        logic       cause;
        logic       osc;
        logic       bod;
        logic       go;
    } exp_t;

    exp_t  exp_q[$];
    string name_q[$];
    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    logic  last_cause = 1'b1;

    localparam logic [1:0] ACT = 2'd0, SLP = 2'd1, STU = 2'd2, HLT = 2'd3;

    task automatic push(input int dc, input logic [1:0] st, input logic [3:0] ce,
                        input logic cause, input logic osc, input logic bod,
                        input logic go, input string nm);
        exp_t e;
        e.tag = cyc + dc; e.st = st; e.ce = ce; e.cause = cause;
        e.osc = osc; e.bod = bod; e.go = go;
        exp_q.push_back(e);
        name_q.push_back(nm);
    endtask

    // monitor: compare in the middle of the high phase
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            #5;
            while (exp_q.size() > 0 && exp_q[0].tag <= cyc) begin
                exp_t  e;
                string nm;
                logic [10:0] act, expv;
                e  = exp_q.pop_front();
                nm = name_q.pop_front();
                act  = {status, clk_en, wake_cause, osc_en, bod_disable, resume_go, core_halt};
                expv = {e.st, e.ce, e.cause, e.osc, e.bod, e.go, (e.st != ACT)};
                checks++;
                if (e.tag != cyc || act !== expv) begin
                    fails++;
                    $display("FAIL %s cyc %0d: st/ce/cause/osc/bod/go/halt actual %b expected %b",
                             nm, cyc, act, expv);
                end
            end
        end
    end

    function automatic logic [3:0] mask_of(input logic [2:0] m);
        case (m)
            3'd1:    return 4'b1100;
            3'd2:    return 4'b0000;
            3'd3:    return 4'b1000;
            3'd6:    return 4'b0000;
            3'd7:    return 4'b1000;
            default: return 4'b1110;
        endcase
    endfunction

    task automatic sleep_cycle(input logic [2:0] m, input logic bodr, input logic use_rst,
                               input int osc_wait, input string nm);
        logic [3:0] ce;
        logic keep, bod_ok;
        ce     = mask_of(m);
        keep   = !(m == 3'd2 || m == 3'd3);
        bod_ok = (m == 3'd2 || m == 3'd3 || m == 3'd6 || m == 3'd7);
        // entry (R1, R2, R4, R8)
        @(negedge clk);
        sleep_en = 1'b1; mode_sel = m; bod_off_req = bodr; sleep_strobe = 1'b1; osc_ready = 1'b0;
        push(1, SLP, ce, last_cause, keep, bodr & bod_ok, 1'b0, {"R2 R8 entry ", nm});
        // inputs changed while asleep are ignored (R9)
        @(negedge clk);
        sleep_strobe = 1'b0; mode_sel = ~m; bod_off_req = ~bodr;
        push(1, SLP, ce, last_cause, keep, bodr & bod_ok, 1'b0, {"R9 held ", nm});
        // disabled interrupt does not wake (R3)
        @(negedge clk);
        irq_req = 8'h10; irq_en = 8'h00;
        push(1, SLP, ce, last_cause, keep, bodr & bod_ok, 1'b0, {"R3 masked ", nm});
        // wake (R3, R7)
        @(negedge clk);
        irq_en = 8'h10; ext_rst_req = use_rst;
        last_cause = use_rst;
        if (keep) push(1, HLT, 4'b1111, last_cause, 1'b1, 1'b0, 1'b0, {"R4 R7 fast wake ", nm});
        else      push(1, STU, ce, last_cause, 1'b1, 1'b0, 1'b0, {"R4 R7 slow wake ", nm});
        if (!keep) begin
            for (int i = 0; i < osc_wait; i++) begin
                @(negedge clk);
                irq_req = '0; ext_rst_req = 1'b0;
                push(1, STU, ce, last_cause, 1'b1, 1'b0, 1'b0, {"R4 startup wait ", nm});
            end
            @(negedge clk);
            irq_req = '0; ext_rst_req = 1'b0; osc_ready = 1'b1;
            push(1, HLT, 4'b1111, last_cause, 1'b1, 1'b0, 1'b0, {"R4 osc up ", nm});
        end
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            irq_req = '0; ext_rst_req = 1'b0;
            push(1, HLT, 4'b1111, last_cause, 1'b1, 1'b0, 1'b0, {"R5 R6 halt ", nm});
        end
        @(negedge clk);
        push(1, ACT, 4'b1111, last_cause, 1'b1, 1'b0, 1'b1, {"R5 release ", nm});
        @(negedge clk);
        push(1, ACT, 4'b1111, last_cause, 1'b1, 1'b0, 1'b0, {"R5 single pulse ", nm});
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        push(1, ACT, 4'b1111, 1'b1, 1'b1, 1'b0, 1'b0, "R6 R7 reset state");
        // R1: strobe with sleep-enable clear is a no-op
        @(negedge clk);
        sleep_en = 1'b0; mode_sel = 3'd2; sleep_strobe = 1'b1;
        push(1, ACT, 4'b1111, 1'b1, 1'b1, 1'b0, 1'b0, "R1 disabled strobe");
        // R7: reset request outside sleep has no effect
        @(negedge clk);
        sleep_strobe = 1'b0; ext_rst_req = 1'b1;
        push(1, ACT, 4'b1111, 1'b1, 1'b1, 1'b0, 1'b0, "R7 reset req while active");
        @(negedge clk);
        ext_rst_req = 1'b0;
        push(1, ACT, 4'b1111, 1'b1, 1'b1, 1'b0, 1'b0, "R1 still active");

        sleep_cycle(3'd0, 1'b1, 1'b0, 0, "idle");
        sleep_cycle(3'd1, 1'b0, 1'b0, 0, "converter-quiet");
        sleep_cycle(3'd2, 1'b1, 1'b0, 3, "power-down");
        sleep_cycle(3'd3, 1'b1, 1'b1, 1, "power-save rst+irq");
        sleep_cycle(3'd6, 1'b1, 1'b1, 0, "standby rst");
        sleep_cycle(3'd7, 1'b0, 1'b0, 0, "ext standby");
        sleep_cycle(3'd5, 1'b1, 1'b0, 0, "reserved code");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R6 %0d expectations never compared", exp_q.size());
        end
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule